// File: doc/BRIEF.md
# Two-Map Interleaving Flattener

This block merges two pooled feature maps into a single flat vector in an output memory. Each source map holds `MAP_ROWS x MAP_COLS` words (32 x 32 by default) in its own external memory. The output memory holds twice that many entries (2048 by default). Entries from the kernel-0 map and the kernel-1 map alternate element by element. Data words are 20-bit signed 4.16 fixed point, and they are moved bit for bit with no arithmetic.

All three memories sit behind one shared bus. The bus has a read enable, a write enable, separate 12-bit read and write addresses, a 20-bit read data input, a 20-bit write data output and a 3-bit memory select.

Every element takes two cycles:
- A read cycle addresses one source map. The memory returns the word on the falling edge of that cycle, and the block captures it on the rising edge that ends the cycle.
- A write cycle then stores that word into the output memory. The memory commits the write on the rising edge that ends the write cycle.

A one-cycle `start` strobe launches a pass. A one-cycle `done` strobe reports that the last entry has been written.

Top module: `ilv_flatten`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to idle. After that edge `rd_en`, `wr_en` and `done` are 0, and `sel`, `rd_addr` and `wr_addr` are 0.
- R2: A `start` sampled high while the block is idle makes the next cycle a read cycle with `sel` = 3'b011 and `rd_addr` = 0.
- R3: In a read cycle, `rd_en` = 1 and `wr_en` = 0. `sel` is 3'b011 when the kernel-0 map is read and 3'b100 when the kernel-1 map is read. `rd_addr` carries the element index i (0 to N-1, N = MAP_ROWS*MAP_COLS).
- R4: Every read cycle is followed at once by a write cycle with `wr_en` = 1, `rd_en` = 0 and `sel` = 3'b101. In that cycle `wr_data` equals, unchanged, the `rd_data` word sampled at the rising edge that ended the read cycle.
- R5: Element i of the kernel-0 map is written to output address 2i, and element i of the kernel-1 map to address 2i+1. Reads run in the order k0[0], k1[0], k0[1], k1[1], and so on, so output addresses are written in ascending order.
- R6: `rd_en` and `wr_en` are never high together, and `sel` is 3'b000 in every cycle in which neither is high.
- R7: `done` is high for exactly one cycle: the cycle right after the write cycle to address 2N-1. That is 4N cycles after the first read cycle of the pass. The block is idle while `done` is high.
- R8: `start` is ignored while a pass is running. The read and write sequence and the pass length stay unchanged.
- R9: A `start` sampled high in the same cycle as the `done` pulse is accepted, so the next cycle is the first read cycle of a new pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch strobe, sampled while idle |
| done | output | 1 | One-cycle end-of-pass strobe |
| rd_en | output | 1 | Memory read enable |
| rd_addr | output | 12 | Read address (element index) |
| rd_data | input | 20 | Read data, valid from the falling edge of the read cycle |
| wr_en | output | 1 | Memory write enable |
| wr_addr | output | 12 | Write address in the output memory |
| wr_data | output | 20 | Write data, 4.16 fixed point |
| sel | output | 3 | Memory select: 000 none, 011 k0 map, 100 k1 map, 101 output |

## Verification
Two functions can land in the same cycle:
- The end-of-pass `done` strobe and the acceptance of a new `start`. The bench raises `start` exactly in the cycle where `done` is seen high. It then judges that the very next cycle is a kernel-0 read of index 0 and that `done` has already dropped.
- A `start` during a running pass and the ongoing read/write alternation. The bench injects a strobe mid-pass and judges that every read and write cycle still has the expected select, address and data, and that the pass still ends exactly 4N cycles after its first read.

Every one of the 2N output entries is compared against the source word computed arithmetically in the bench, for several data patterns that include negative values.

// File: rtl/ilv_flatten_pkg.sv
// Shared constants and types for the interleaving flattener.
// Assumes a 3-bit memory select shared by all memories on the bus.
package ilv_flatten_pkg;
    localparam logic [2:0] SEL_NONE   = 3'b000;
    localparam logic [2:0] SEL_SRC_K0 = 3'b011;
    localparam logic [2:0] SEL_SRC_K1 = 3'b100;
    localparam logic [2:0] SEL_DST    = 3'b101;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_t;
endpackage

// File: rtl/ilv_sequencer.sv
// Sequencer: walks the element index and the map bit through
// alternating read and write phases, and raises done after the last write.
// Assumes start is a strobe; it is ignored unless the phase is idle.
module ilv_sequencer
    import ilv_flatten_pkg::*;
#(
    parameter int N     = 1024,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output phase_t           phase,
    output logic [IDX_W-1:0] idx,
    output logic             map_k1,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

    // Phase, index and map-bit progression, plus the done strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            idx    <= '0;
            map_k1 <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase  <= PH_READ;
                        idx    <= '0;
                        map_k1 <= 1'b0;
                    end
                end
                PH_READ: phase <= PH_WRITE;
                PH_WRITE: begin
                    if (map_k1 && idx == LAST_IDX) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        phase  <= PH_READ;
                        map_k1 <= ~map_k1;
                        if (map_k1) idx <= idx + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R7: done never lasts more than one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a running read phase always proceeds to a write phase, whatever start does
    a_r8_read_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_READ) |=> (phase == PH_WRITE));

    // R7: the block is idle whenever done is high
    a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == PH_IDLE));
endmodule

// File: rtl/ilv_capture.sv
// Capture register: latches the read data word at the edge that ends a read phase.
// Assumes the memory drives rd_data from the falling edge of the read phase.
module ilv_capture #(
    parameter int DATA_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    // Hold the captured word until the next read phase
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end

    // R4: the held word changes only on a load
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout));
endmodule

// File: rtl/ilv_bus_drive.sv
// Bus driver: turns the current phase, index and map bit into the
// shared memory bus signals. Purely combinational.
// Assumes ADDR_W > IDX_W, so that the doubled write address fits.
module ilv_bus_drive
    import ilv_flatten_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 20
) (
    input  phase_t             phase,
    input  logic [IDX_W-1:0]   idx,
    input  logic               map_k1,
    input  logic [DATA_W-1:0]  held,
    output logic               rd_en,
    output logic               wr_en,
    output logic [2:0]         sel,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0]  wr_data
);
    // Decode the phase into enables, select, addresses and write data
    always_comb begin
        rd_en   = 1'b0;
        wr_en   = 1'b0;
        sel     = SEL_NONE;
        rd_addr = '0;
        wr_addr = '0;
        wr_data = '0;
        case (phase)
            PH_READ: begin
                rd_en   = 1'b1;
                sel     = map_k1 ? SEL_SRC_K1 : SEL_SRC_K0;
                rd_addr = ADDR_W'(idx);
            end
            PH_WRITE: begin
                wr_en   = 1'b1;
                sel     = SEL_DST;
                wr_addr = ADDR_W'({idx, map_k1});
                wr_data = held;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ilv_flatten.sv
// Top: interleaving flattener. Copies two MAP_ROWS x MAP_COLS maps into one
// vector of 2N words, alternating kernel-0 and kernel-1 entries.
// Assumes single-cycle memories on a shared, select-switched bus.
module ilv_flatten
    import ilv_flatten_pkg::*;
#(
    parameter int MAP_ROWS = 32,
    parameter int MAP_COLS = 32,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [2:0]        sel
);
    localparam int N     = MAP_ROWS * MAP_COLS;
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    phase_t             phase;
    logic [IDX_W-1:0]   idx;
    logic               map_k1;
    logic [DATA_W-1:0]  held;

    ilv_sequencer #(.N(N), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .phase(phase), .idx(idx), .map_k1(map_k1), .done(done)
    );

    ilv_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .load(phase == PH_READ),
        .din(rd_data), .dout(held)
    );

    ilv_bus_drive #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .phase(phase), .idx(idx), .map_k1(map_k1), .held(held),
        .rd_en(rd_en), .wr_en(wr_en), .sel(sel),
        .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // R2 / R9: an accepted start leads to the kernel-0 read of index 0
    a_r2_start_first_read: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && start) |=> (rd_en && sel == SEL_SRC_K0 && rd_addr == '0));

    // R3: reads only address a source map
    a_r3_src_select: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (sel == SEL_SRC_K0 || sel == SEL_SRC_K1));

    // R4: a write follows each read and carries the word read, unchanged
    a_r4_copy_word: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (wr_en && sel == SEL_DST && wr_data == $past(rd_data)));

    // R5: write address is twice the read index, plus one for the kernel-1 map
    a_r5_interleave_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en ##1 wr_en) |-> ((wr_addr >> 1) == $past(rd_addr)
                               && wr_addr[0] == ($past(sel) == SEL_SRC_K1)));

    // R6: enables exclusive, select parked when the bus is unused
    a_r6_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));
    a_r6_sel_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en) |-> (sel == SEL_NONE));

    // R7: done comes right after the write of the last output address
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && $past(wr_addr) == ADDR_W'(2 * N - 1)));
endmodule

// File: tb/test_ilv_flatten.sv
// Bench for ilv_flatten: memory models on the shared bus, a cycle monitor
// and full comparison of the output vector after each pass.
module test_ilv_flatten;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 1024;
    localparam int PASS_CYC   = 4 * N;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        done, rd_en, wr_en;
    logic [11:0] rd_addr, wr_addr;
    logic [19:0] rd_data, wr_data;
    logic [2:0]  sel;

    logic [19:0] k0_mem [N];
    logic [19:0] k1_mem [N];
    logic [19:0] out_mem [2*N];

    int checks   = 0;
    int failures = 0;
    bit mon_on   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilv_flatten i_ilv_flatten (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sel(sel)
    );

    // Source memories answer on the falling edge
    always @(negedge clk) begin
        if (rd_en && sel == 3'b011)      rd_data <= k0_mem[rd_addr[9:0]];
        else if (rd_en && sel == 3'b100) rd_data <= k1_mem[rd_addr[9:0]];
    end

    // Output memory commits on the rising edge
    always @(posedge clk) begin
        if (wr_en && sel == 3'b101) out_mem[wr_addr[10:0]] <= wr_data;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected word for output slot k: even from kernel-0, odd from kernel-1
    function automatic logic [19:0] src_word(input int k);
        return k[0] ? k1_mem[k >> 1] : k0_mem[k >> 1];
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < N; i++) begin
            k0_mem[i] = 20'(i * 7919 + seed * 131 + 3);
            k1_mem[i] = ~20'(i * 40503 + seed * 977);
        end
    endtask

    task automatic verify_out(input string tag);
        for (int a = 0; a < 2*N; a++)
            chk(out_mem[a] == src_word(a), tag, 32'(out_mem[a]), 32'(src_word(a)));
    endtask

    // Waits for done; counts cycles from the current (first read) cycle
    task automatic wait_done(input int inject_at, output int n);
        n = 0;
        while (!done && n < PASS_CYC + 200) begin
            @(negedge clk);
            n++;
            start = (n == inject_at);
        end
        start = 1'b0;
        if (!done) chk(1'b0, "watchdog R7 done missing", 32'(n), 32'(PASS_CYC));
    endtask

    // Cycle monitor for R3, R4, R5, R6
    int exp_k = 0;
    int prev_k = 0;
    bit prev_rd = 1'b0;
    always @(negedge clk) begin
        if (!rst_n || !mon_on) begin
            exp_k = 0;
            prev_rd = 1'b0;
        end else begin
            chk(!(rd_en && wr_en), "R6 enables exclusive", {30'd0, rd_en, wr_en}, 32'd0);
            if (!rd_en && !wr_en) begin
                chk(sel == 3'b000, "R6 idle select", 32'(sel), 32'd0);
                chk(!prev_rd, "R4 write missing after read", 32'(prev_rd), 32'd0);
                prev_rd = 1'b0;
            end else if (rd_en) begin
                chk(sel == (exp_k[0] ? 3'b100 : 3'b011), "R3 read select", 32'(sel),
                    32'(exp_k[0] ? 3'b100 : 3'b011));
                chk(rd_addr == 12'(exp_k >> 1), "R5 read order", 32'(rd_addr), 32'(exp_k >> 1));
                prev_k = exp_k;
                exp_k++;
                prev_rd = 1'b1;
            end else begin
                chk(prev_rd && sel == 3'b101, "R4 write after read", {29'd0, sel}, 32'h5);
                chk(wr_addr == 12'(prev_k), "R5 write address", 32'(wr_addr), 32'(prev_k));
                chk(wr_data == src_word(prev_k), "R4 copied word", 32'(wr_data),
                    32'(src_word(prev_k)));
                prev_rd = 1'b0;
            end
            if (done) exp_k = 0;
        end
    end

    task automatic chk_idle(input string tag);
        chk(!rd_en && !wr_en && !done && sel == 3'b000 && rd_addr == 0 && wr_addr == 0,
            tag, {rd_en, wr_en, done, sel, rd_addr, wr_addr}, 32'd0);
    endtask

    initial begin
        int n;
        #(CLK_PERIOD * 100000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0;
        start = 1'b0;
        for (int a = 0; a < 2*N; a++) out_mem[a] = '0;
        repeat (3) @(negedge clk);
        chk_idle("R1 reset state");
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (4) @(negedge clk);
        chk_idle("R1 idle without start");

        // Pass 1 with a start strobe injected mid-pass (R8)
        fill(1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(rd_en && sel == 3'b011 && rd_addr == 0, "R2 first read",
            {rd_en, sel, rd_addr}, {1'b1, 3'b011, 12'd0});
        wait_done(1000, n);
        chk(n == PASS_CYC, "R7 R8 pass length", 32'(n), 32'(PASS_CYC));
        verify_out("R5 pass1 output");

        // Pass 2 started in the done cycle (R9)
        fill(2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(rd_en && sel == 3'b011 && rd_addr == 0 && !done, "R9 start at done",
            {done, rd_en, sel, rd_addr}, {1'b0, 1'b1, 3'b011, 12'd0});
        wait_done(0, n);
        chk(n == PASS_CYC, "R7 pass2 length", 32'(n), 32'(PASS_CYC));
        verify_out("R5 pass2 output");
        @(negedge clk);
        chk_idle("R7 done single pulse");

        // Pass 3 cut by reset (R1), then a full pass with negative words
        fill(3);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (500) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R1 reset mid-pass");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 idle after reset");
        for (int i = 0; i < N; i++) k0_mem[i] = 20'h80000 | 20'(i * 3);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(rd_en && sel == 3'b011 && rd_addr == 0, "R2 restart after reset",
            {rd_en, sel, rd_addr}, {1'b1, 3'b011, 12'd0});
        wait_done(2047, n);
        chk(n == PASS_CYC, "R7 R8 pass3 length", 32'(n), 32'(PASS_CYC));
        verify_out("R5 pass3 output");
        repeat (3) @(negedge clk);
        chk_idle("R6 idle after pass");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule